// File: doc/BRIEF.md
# Segmented MMU Address Translator

This block turns a 32-bit virtual address into a physical address through two table lookups tagged by the current address-space context. The first lookup reads a segment map and gets an 8-bit page-group number. The second lookup reads a page-entry array indexed by context, group and page number. Each request carries a read/write flag and a user/supervisor flag. The block answers with one single-cycle completion pulse. That pulse carries either a physical address with read/write/execute permission bits, or a nonzero fault code. While it does this, the block keeps the accessed and modified bits of the page entry up to date in place.

A host loads the segment map, the page entries and the current context through three plain write ports. Each array keeps only the low bits of each index field. The counts are set by parameters: by default 2 context bits and 4 segment bits for the segment map, and 2 context bits, 2 group bits and all 6 page bits for the page array. Indices that differ only in higher bits share one storage slot. The full-size map is reached by raising those parameters to the full field widths.

A request is taken when `req_valid` is high while `req_ready` is high. It then moves through the segment read, the page-entry read and, when needed, a write-back step before it completes.

Top module: `mmu_xlat`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_done` is 0, and the context register holds 0.
- R2: The segment map is indexed by {context, address bits 29:18}. The page array is indexed by {context, group, address bits 17:12}. Address bits 31:30 have no effect on the result.
- R3: If page-entry bit 31 (valid) is 0, the response carries fault code 1 and the entry is not rewritten. When a response has a nonzero fault, its address and permission fields read 0.
- R4: For a valid entry, bit 25 (accessed) is set. On a write, bit 24 (modified) is also set. The entry is rewritten only when one of these two bits changes. A rewrite adds one cycle: `rsp_done` arrives 4 cycles after the accepting edge with a rewrite and 3 cycles after it without one.
- R5: A user access (`req_user`=1) to an entry with bit 29 (supervisor-only) set returns fault code 2. The accessed and modified updates of R4 still happen.
- R6: A write to an entry with bit 30 (write-enable) clear returns fault code 4. When both apply, the supervisor fault of R5 is reported instead.
- R7: A successful response has permission bits read (bit 0) and execute (bit 2) set. Write (bit 1) is set only when write-enable is set and the modified bit was already set before this access.
- R8: The physical address is built from three parts: bits 31:28 are 0xF when entry bit 26 (I/O) is set and 0 otherwise, bits 27:12 are entry bits 15:0, and bits 11:0 are the address offset.
- R9: One request is in flight at a time. `req_ready` drops in the cycle after acceptance. `rsp_done` is a single-cycle pulse, and `req_ready` returns the cycle after it.
- R10: When a host page-entry write and a write-back hit the same entry on the same clock edge, the host value is kept.
- R11: A context write loads the context register. Each request uses the context that was current when it was accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Translator idle, request taken this edge |
| req_addr | input | 32 | Virtual address |
| req_write | input | 1 | 1 = write access |
| req_user | input | 1 | 1 = user-mode access |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_fault | output | 3 | 0 ok, 1 invalid, 2 supervisor-only, 4 write-protected |
| rsp_prot | output | 3 | Bit 0 read, bit 1 write, bit 2 execute |
| rsp_paddr | output | 32 | Physical address |
| ctx_wr_en | input | 1 | Load context register |
| ctx_wr_val | input | 4 | New context |
| smap_wr_en | input | 1 | Segment-map write strobe |
| smap_wr_ctx | input | 4 | Segment-map write context |
| smap_wr_seg | input | 12 | Segment-map write segment number |
| smap_wr_grp | input | 8 | Page group to store |
| pte_wr_en | input | 1 | Page-entry write strobe |
| pte_wr_ctx | input | 4 | Page-entry write context |
| pte_wr_grp | input | 8 | Page-entry write group |
| pte_wr_pg | input | 6 | Page-entry write page number |
| pte_wr_data | input | 32 | Page entry to store |

## Verification
A host page-entry write and the translator's own accessed/modified write-back can land on the same entry on the same clock edge. The bench provokes this by starting a read to a page whose accessed bit is clear. It waits until the response has not arrived by the third cycle, which means the write-back step is running. At that moment it drives a host write to the same entry, with the accessed bit clear and a different frame number. The outcome is judged at the ports by reading that page again: a 4-cycle latency and the new frame number show that the host value survived, while a 3-cycle latency would mean the write-back overwrote it.

// File: rtl/mmu_xlat_pkg.sv
package mmu_xlat_pkg;

    // Address field widths
    localparam int VA_W   = 32;
    localparam int PA_W   = 32;
    localparam int OFF_W  = 12;
    localparam int PG_W   = 6;
    localparam int SEG_W  = 12;
    localparam int CTX_W  = 4;
    localparam int GRP_W  = 8;
    localparam int PTE_W  = 32;
    localparam int PFN_W  = 16;
    localparam int HI_W   = PA_W - PFN_W - OFF_W;

    localparam int SEG_LO = OFF_W + PG_W;
    localparam int SEG_HI = SEG_LO + SEG_W - 1;
    localparam int PG_LO  = OFF_W;
    localparam int PG_HI  = OFF_W + PG_W - 1;

    // Page entry flag positions
    localparam int B_VALID = 31;
    localparam int B_WEN   = 30;
    localparam int B_SUPER = 29;
    localparam int B_CACHE = 28;
    localparam int B_IO    = 26;
    localparam int B_ACC   = 25;
    localparam int B_MOD   = 24;

    typedef enum logic [2:0] {
        FLT_NONE    = 3'd0,
        FLT_INVALID = 3'd1,
        FLT_SUPER   = 3'd2,
        FLT_WPROT   = 3'd4
    } fault_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SEG,
        ST_PTE,
        ST_WB,
        ST_RSP
    } walk_state_e;

    // bit 0 read, bit 1 write, bit 2 exec
    typedef struct packed {
        logic exec;
        logic write;
        logic read;
    } prot_t;

    typedef struct packed {
        fault_e          fault;
        prot_t           prot;
        logic [PA_W-1:0] paddr;
    } xlat_rsp_t;

    typedef struct packed {
        logic [PTE_W-1:0] entry;
        logic             need_wb;
        xlat_rsp_t        rsp;
    } eval_t;

    // Decide the outcome of one access against a fetched page entry.
    function automatic eval_t pte_eval(
        input logic [PTE_W-1:0] pte,
        input logic             is_wr,
        input logic             is_usr,
        input logic [OFF_W-1:0] off
    );
        eval_t r;
        logic  dirty;
        r         = '0;
        r.entry   = pte;
        dirty     = 1'b0;
        if (!pte[B_VALID]) begin
            r.rsp.fault = FLT_INVALID;
        end else begin
            dirty            = is_wr && !pte[B_MOD];
            r.need_wb        = !pte[B_ACC] || dirty;
            r.entry[B_ACC]   = 1'b1;
            if (dirty) begin
                r.entry[B_MOD] = 1'b1;
            end
            if (is_usr && pte[B_SUPER]) begin
                r.rsp.fault = FLT_SUPER;
            end else if (is_wr && !pte[B_WEN]) begin
                r.rsp.fault = FLT_WPROT;
            end else begin
                r.rsp.fault      = FLT_NONE;
                r.rsp.prot.read  = 1'b1;
                r.rsp.prot.exec  = 1'b1;
                r.rsp.prot.write = pte[B_WEN] && pte[B_MOD];
                r.rsp.paddr      = {(pte[B_IO] ? {HI_W{1'b1}} : {HI_W{1'b0}}),
                                    pte[PFN_W-1:0], off};
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/mmu_seg_map.sv
module mmu_seg_map
    import mmu_xlat_pkg::*;
#(
    parameter int CTX_KEEP = 2,
    parameter int SEG_KEEP = 4
) (
    input  logic             clk,
    input  logic             wr_en,
    input  logic [CTX_W-1:0] wr_ctx,
    input  logic [SEG_W-1:0] wr_seg,
    input  logic [GRP_W-1:0] wr_grp,
    input  logic [CTX_W-1:0] rd_ctx,
    input  logic [SEG_W-1:0] rd_seg,
    output logic [GRP_W-1:0] rd_grp
);

    localparam int AW    = CTX_KEEP + SEG_KEEP;
    localparam int DEPTH = 1 << AW;

    logic [GRP_W-1:0] store [DEPTH];
    logic [AW-1:0]    wr_idx;
    logic [AW-1:0]    rd_idx;

    assign wr_idx = {wr_ctx[CTX_KEEP-1:0], wr_seg[SEG_KEEP-1:0]};
    assign rd_idx = {rd_ctx[CTX_KEEP-1:0], rd_seg[SEG_KEEP-1:0]};

    always_ff @(posedge clk) begin
        if (wr_en) begin
            store[wr_idx] <= wr_grp;
        end
    end

    assign rd_grp = store[rd_idx];

    logic unused_hi;
    assign unused_hi = ^{wr_ctx, wr_seg, rd_ctx, rd_seg};

endmodule

// File: rtl/mmu_pte_store.sv
module mmu_pte_store
    import mmu_xlat_pkg::*;
#(
    parameter int CTX_KEEP = 2,
    parameter int GRP_KEEP = 2
) (
    input  logic             clk,
    // host port, wins over write-back on the same entry
    input  logic             host_en,
    input  logic [CTX_W-1:0] host_ctx,
    input  logic [GRP_W-1:0] host_grp,
    input  logic [PG_W-1:0]  host_pg,
    input  logic [PTE_W-1:0] host_data,
    // walker port: read and write-back share one index
    input  logic [CTX_W-1:0] walk_ctx,
    input  logic [GRP_W-1:0] walk_grp,
    input  logic [PG_W-1:0]  walk_pg,
    input  logic             wb_en,
    input  logic [PTE_W-1:0] wb_data,
    output logic [PTE_W-1:0] rd_data
);

    localparam int AW    = CTX_KEEP + GRP_KEEP + PG_W;
    localparam int DEPTH = 1 << AW;

    logic [PTE_W-1:0] store [DEPTH];
    logic [AW-1:0]    host_idx;
    logic [AW-1:0]    walk_idx;
    logic             wb_keep;

    assign host_idx = {host_ctx[CTX_KEEP-1:0], host_grp[GRP_KEEP-1:0], host_pg};
    assign walk_idx = {walk_ctx[CTX_KEEP-1:0], walk_grp[GRP_KEEP-1:0], walk_pg};

    // a write-back yields only when the host targets the same slot
    assign wb_keep = wb_en && !(host_en && (host_idx == walk_idx));

    always_ff @(posedge clk) begin
        if (wb_keep) begin
            store[walk_idx] <= wb_data;
        end
        if (host_en) begin
            store[host_idx] <= host_data;
        end
    end

    assign rd_data = store[walk_idx];

    logic unused_hi;
    assign unused_hi = ^{host_ctx, host_grp, walk_ctx, walk_grp};

endmodule

// File: rtl/mmu_walk_fsm.sv
module mmu_walk_fsm
    import mmu_xlat_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    input  logic [VA_W-1:0]  req_addr,
    input  logic             req_write,
    input  logic             req_user,
    input  logic [CTX_W-1:0] cur_ctx,
    output logic             req_ready,
    // segment map read
    output logic [CTX_W-1:0] map_ctx,
    output logic [SEG_W-1:0] map_seg,
    input  logic [GRP_W-1:0] map_grp,
    // page entry read / write-back
    output logic [CTX_W-1:0] pte_ctx,
    output logic [GRP_W-1:0] pte_grp,
    output logic [PG_W-1:0]  pte_pg,
    input  logic [PTE_W-1:0] pte_rd,
    output logic             wb_en,
    output logic [PTE_W-1:0] wb_data,
    // response
    output logic             rsp_done,
    output xlat_rsp_t        rsp
);

    walk_state_e      state;
    logic [CTX_W-1:0] ctx_q;
    logic [SEG_W-1:0] seg_q;
    logic [PG_W-1:0]  pg_q;
    logic [OFF_W-1:0] off_q;
    logic             wr_q;
    logic             usr_q;
    logic [GRP_W-1:0] grp_q;
    logic [PTE_W-1:0] wb_q;
    xlat_rsp_t        rsp_q;
    eval_t            ev;

    assign ev = pte_eval(pte_rd, wr_q, usr_q, off_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            ctx_q <= '0;
            seg_q <= '0;
            pg_q  <= '0;
            off_q <= '0;
            wr_q  <= 1'b0;
            usr_q <= 1'b0;
            grp_q <= '0;
            wb_q  <= '0;
            rsp_q <= '0;
        end else begin
            case (state)
                ST_IDLE: begin
                    if (req_valid) begin
                        ctx_q <= cur_ctx;
                        seg_q <= req_addr[SEG_HI:SEG_LO];
                        pg_q  <= req_addr[PG_HI:PG_LO];
                        off_q <= req_addr[OFF_W-1:0];
                        wr_q  <= req_write;
                        usr_q <= req_user;
                        state <= ST_SEG;
                    end
                end
                ST_SEG: begin
                    grp_q <= map_grp;
                    state <= ST_PTE;
                end
                ST_PTE: begin
                    rsp_q <= ev.rsp;
                    wb_q  <= ev.entry;
                    state <= ev.need_wb ? ST_WB : ST_RSP;
                end
                ST_WB: begin
                    state <= ST_RSP;
                end
                ST_RSP: begin
                    state <= ST_IDLE;
                end
                default: begin
                    state <= ST_IDLE;
                end
            endcase
        end
    end

    assign req_ready = (state == ST_IDLE);
    assign map_ctx   = ctx_q;
    assign map_seg   = seg_q;
    assign pte_ctx   = ctx_q;
    assign pte_grp   = grp_q;
    assign pte_pg    = pg_q;
    assign wb_en     = (state == ST_WB);
    assign wb_data   = wb_q;
    assign rsp_done  = (state == ST_RSP);
    assign rsp       = rsp_q;

    logic unused_addr;
    assign unused_addr = ^req_addr[VA_W-1:SEG_HI+1];

endmodule

// File: rtl/mmu_xlat.sv
module mmu_xlat
    import mmu_xlat_pkg::*;
#(
    parameter int CTX_KEEP = 2,
    parameter int SEG_KEEP = 4,
    parameter int GRP_KEEP = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        req_valid,
    output logic        req_ready,
    input  logic [31:0] req_addr,
    input  logic        req_write,
    input  logic        req_user,
    output logic        rsp_done,
    output logic [2:0]  rsp_fault,
    output logic [2:0]  rsp_prot,
    output logic [31:0] rsp_paddr,
    input  logic        ctx_wr_en,
    input  logic [3:0]  ctx_wr_val,
    input  logic        smap_wr_en,
    input  logic [3:0]  smap_wr_ctx,
    input  logic [11:0] smap_wr_seg,
    input  logic [7:0]  smap_wr_grp,
    input  logic        pte_wr_en,
    input  logic [3:0]  pte_wr_ctx,
    input  logic [7:0]  pte_wr_grp,
    input  logic [5:0]  pte_wr_pg,
    input  logic [31:0] pte_wr_data
);

    logic [CTX_W-1:0] ctx_q;
    logic [CTX_W-1:0] map_ctx;
    logic [SEG_W-1:0] map_seg;
    logic [GRP_W-1:0] map_grp;
    logic [CTX_W-1:0] pte_ctx;
    logic [GRP_W-1:0] pte_grp;
    logic [PG_W-1:0]  pte_pg;
    logic [PTE_W-1:0] pte_rd;
    logic             wb_en;
    logic [PTE_W-1:0] wb_data;
    xlat_rsp_t        rsp;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctx_q <= '0;
        end else if (ctx_wr_en) begin
            ctx_q <= ctx_wr_val;
        end
    end

    mmu_seg_map #(
        .CTX_KEEP (CTX_KEEP),
        .SEG_KEEP (SEG_KEEP)
    ) i_seg_map (
        .clk    (clk),
        .wr_en  (smap_wr_en),
        .wr_ctx (smap_wr_ctx),
        .wr_seg (smap_wr_seg),
        .wr_grp (smap_wr_grp),
        .rd_ctx (map_ctx),
        .rd_seg (map_seg),
        .rd_grp (map_grp)
    );

    mmu_pte_store #(
        .CTX_KEEP (CTX_KEEP),
        .GRP_KEEP (GRP_KEEP)
    ) i_pte_store (
        .clk       (clk),
        .host_en   (pte_wr_en),
        .host_ctx  (pte_wr_ctx),
        .host_grp  (pte_wr_grp),
        .host_pg   (pte_wr_pg),
        .host_data (pte_wr_data),
        .walk_ctx  (pte_ctx),
        .walk_grp  (pte_grp),
        .walk_pg   (pte_pg),
        .wb_en     (wb_en),
        .wb_data   (wb_data),
        .rd_data   (pte_rd)
    );

    mmu_walk_fsm i_walk (
        .clk       (clk),
        .rst       (rst),
        .req_valid (req_valid),
        .req_addr  (req_addr),
        .req_write (req_write),
        .req_user  (req_user),
        .cur_ctx   (ctx_q),
        .req_ready (req_ready),
        .map_ctx   (map_ctx),
        .map_seg   (map_seg),
        .map_grp   (map_grp),
        .pte_ctx   (pte_ctx),
        .pte_grp   (pte_grp),
        .pte_pg    (pte_pg),
        .pte_rd    (pte_rd),
        .wb_en     (wb_en),
        .wb_data   (wb_data),
        .rsp_done  (rsp_done),
        .rsp       (rsp)
    );

    assign rsp_fault = rsp.fault;
    assign rsp_prot  = rsp.prot;
    assign rsp_paddr = rsp.paddr;

endmodule

// File: rtl/mmu_xlat_chk.sv
module mmu_xlat_chk (
    input logic        clk,
    input logic        rst,
    input logic        req_valid,
    input logic        req_ready,
    input logic        rsp_done,
    input logic [2:0]  rsp_fault,
    input logic [2:0]  rsp_prot,
    input logic [31:0] rsp_paddr,
    input logic        wb_en
);

    // R9: completion lasts exactly one cycle
    a_r9_done_pulse: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> !rsp_done);

    // R9: the translator is free again right after completing
    a_r9_ready_after_done: assert property (@(posedge clk) disable iff (rst)
        rsp_done |=> req_ready);

    // R9: an accepted request blocks the next one
    a_r9_busy_after_accept: assert property (@(posedge clk) disable iff (rst)
        (req_valid && req_ready) |=> !req_ready);

    // R4: the write-back step is followed directly by the response
    a_r4_wb_then_done: assert property (@(posedge clk) disable iff (rst)
        wb_en |=> rsp_done);

    // R3: a faulting response carries no address and no permissions
    a_r3_fault_clears_result: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault != 3'd0) |-> (rsp_paddr == 32'd0 && rsp_prot == 3'd0));

    // R6: at most one fault cause is reported
    a_r6_fault_onehot: assert property (@(posedge clk) disable iff (rst)
        rsp_done |-> $onehot0(rsp_fault));

    // R7: successful responses always grant read and execute
    a_r7_read_exec: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault == 3'd0) |-> (rsp_prot[0] && rsp_prot[2]));

    // R8: the top nibble is either all ones or all zeros
    a_r8_io_nibble: assert property (@(posedge clk) disable iff (rst)
        (rsp_done && rsp_fault == 3'd0) |->
            (rsp_paddr[31:28] == 4'h0 || rsp_paddr[31:28] == 4'hF));

endmodule

bind mmu_xlat mmu_xlat_chk i_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .rsp_done  (rsp_done),
    .rsp_fault (rsp_fault),
    .rsp_prot  (rsp_prot),
    .rsp_paddr (rsp_paddr),
    .wb_en     (wb_en)
);

// File: tb/test_mmu_xlat.sv
`timescale 1ns/1ps
module test_mmu_xlat;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic        req_user = 1'b0;
    logic        rsp_done;
    logic [2:0]  rsp_fault;
    logic [2:0]  rsp_prot;
    logic [31:0] rsp_paddr;
    logic        ctx_wr_en = 1'b0;
    logic [3:0]  ctx_wr_val = '0;
    logic        smap_wr_en = 1'b0;
    logic [3:0]  smap_wr_ctx = '0;
    logic [11:0] smap_wr_seg = '0;
    logic [7:0]  smap_wr_grp = '0;
    logic        pte_wr_en = 1'b0;
    logic [3:0]  pte_wr_ctx = '0;
    logic [7:0]  pte_wr_grp = '0;
    logic [5:0]  pte_wr_pg = '0;
    logic [31:0] pte_wr_data = '0;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    mmu_xlat i_mmu_xlat (
        .clk(clk), .rst(rst),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_write(req_write), .req_user(req_user),
        .rsp_done(rsp_done), .rsp_fault(rsp_fault), .rsp_prot(rsp_prot),
        .rsp_paddr(rsp_paddr),
        .ctx_wr_en(ctx_wr_en), .ctx_wr_val(ctx_wr_val),
        .smap_wr_en(smap_wr_en), .smap_wr_ctx(smap_wr_ctx),
        .smap_wr_seg(smap_wr_seg), .smap_wr_grp(smap_wr_grp),
        .pte_wr_en(pte_wr_en), .pte_wr_ctx(pte_wr_ctx), .pte_wr_grp(pte_wr_grp),
        .pte_wr_pg(pte_wr_pg), .pte_wr_data(pte_wr_data)
    );

    typedef struct packed {
        logic [31:0] addr;
        logic        wr;
        logic        usr;
        logic [2:0]  fault;
        logic [2:0]  prot;
        logic [31:0] pa;
        logic [3:0]  lat;
        logic [3:0]  rq;
    } vec_t;

    // Context 1 is current; see page setup in the main sequence.
    localparam int NV = 12;
    localparam vec_t VT [NV] = '{
        // R4 R8: first read sets accessed, rewrite, 4 cycles
        '{32'h0000_0567, 1'b0, 1'b0, 3'd0, 3'b101, 32'h0123_4567, 4'd4, 4'd4},
        // R4: second read, nothing changes, 3 cycles
        '{32'h0000_0567, 1'b0, 1'b0, 3'd0, 3'b101, 32'h0123_4567, 4'd3, 4'd4},
        // R7: first write sets modified, write not granted yet
        '{32'h0000_0010, 1'b1, 1'b1, 3'd0, 3'b101, 32'h0123_4010, 4'd4, 4'd7},
        // R7: page now dirty, write granted
        '{32'h0000_0010, 1'b1, 1'b1, 3'd0, 3'b111, 32'h0123_4010, 4'd3, 4'd7},
        // R3: invalid entry, no rewrite
        '{32'h0000_1000, 1'b0, 1'b0, 3'd1, 3'b000, 32'h0000_0000, 4'd3, 4'd3},
        // R5: user read of supervisor page
        '{32'h0000_2ABC, 1'b0, 1'b1, 3'd2, 3'b000, 32'h0000_0000, 4'd3, 4'd5},
        // R7: supervisor read of same page, write enabled and dirty
        '{32'h0000_2ABC, 1'b0, 1'b0, 3'd0, 3'b111, 32'h000A_BABC, 4'd3, 4'd7},
        // R8: I/O page sets top nibble
        '{32'h0000_3FFF, 1'b0, 1'b0, 3'd0, 3'b101, 32'hFBEE_FFFF, 4'd3, 4'd8},
        // R6: write to read-only page faults, modified still set
        '{32'h0000_3000, 1'b1, 1'b0, 3'd4, 3'b000, 32'h0000_0000, 4'd4, 4'd6},
        // R6: supervisor fault wins over write fault
        '{32'h0000_4000, 1'b1, 1'b1, 3'd2, 3'b000, 32'h0000_0000, 4'd3, 4'd6},
        // R2: segment 1 page 5, address bits 31:30 set
        '{32'hC004_5123, 1'b0, 1'b0, 3'd0, 3'b111, 32'h0004_2123, 4'd3, 4'd2},
        // R4: read-only page now already modified, no rewrite
        '{32'h0000_3000, 1'b0, 1'b0, 3'd0, 3'b101, 32'hFBEE_F000, 4'd3, 4'd4}
    };

    task automatic chk(input string rq, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic load_smap(input logic [3:0] c, input logic [11:0] s, input logic [7:0] g);
        @(negedge clk);
        smap_wr_en = 1'b1; smap_wr_ctx = c; smap_wr_seg = s; smap_wr_grp = g;
        @(negedge clk);
        smap_wr_en = 1'b0;
    endtask

    task automatic load_pte(input logic [3:0] c, input logic [7:0] g,
                            input logic [5:0] p, input logic [31:0] d);
        @(negedge clk);
        pte_wr_en = 1'b1; pte_wr_ctx = c; pte_wr_grp = g; pte_wr_pg = p; pte_wr_data = d;
        @(negedge clk);
        pte_wr_en = 1'b0;
    endtask

    task automatic set_ctx(input logic [3:0] c);
        @(negedge clk);
        ctx_wr_en = 1'b1; ctx_wr_val = c;
        @(negedge clk);
        ctx_wr_en = 1'b0;
    endtask

    // Issue one request; optionally hit the same entry from the host
    // during the write-back cycle (third cycle without a response).
    task automatic run_req(input logic [31:0] a, input logic w, input logic u,
                           input logic coll, input logic [31:0] cdata,
                           output logic [2:0] f, output logic [2:0] p,
                           output logic [31:0] pa, output int lat,
                           output logic busy_seen);
        @(negedge clk);
        req_addr = a; req_write = w; req_user = u; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        busy_seen = !req_ready;
        lat = 0; f = '0; p = '0; pa = '0;
        for (int n = 1; n <= 8; n++) begin
            if (n > 1) @(negedge clk);
            pte_wr_en = 1'b0;
            if (rsp_done) begin
                f = rsp_fault; p = rsp_prot; pa = rsp_paddr; lat = n;
                break;
            end
            if (coll && n == 3) begin
                pte_wr_ctx = 4'd1; pte_wr_grp = 8'd1; pte_wr_pg = 6'd6;
                pte_wr_data = cdata; pte_wr_en = 1'b1;
            end
        end
    endtask

    task automatic check_req(input string rq, input logic [31:0] a, input logic w,
                             input logic u, input logic [2:0] ef, input logic [2:0] ep,
                             input logic [31:0] epa, input int elat);
        logic [2:0]  f;
        logic [2:0]  p;
        logic [31:0] pa;
        int          lat;
        logic        busy;
        run_req(a, w, u, 1'b0, 32'd0, f, p, pa, lat, busy);
        chk(rq, "fault", {29'd0, f}, {29'd0, ef});
        chk(rq, "prot", {29'd0, p}, {29'd0, ep});
        chk(rq, "paddr", pa, epa);
        chk(rq, "latency", lat, elat);
        chk("R9", "busy after accept", {31'd0, busy}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : main
        logic [2:0]  f;
        logic [2:0]  p;
        logic [31:0] pa;
        int          lat;
        logic        busy;

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1", "ready", {31'd0, req_ready}, 32'd1);
        chk("R1", "done", {31'd0, rsp_done}, 32'd0);

        // Map setup
        load_smap(4'd0, 12'd0, 8'd0);
        load_pte (4'd0, 8'd0, 6'd0, 32'hC300_0055);
        load_smap(4'd1, 12'd0, 8'd1);
        load_smap(4'd1, 12'd1, 8'd2);
        load_smap(4'd2, 12'd0, 8'd3);
        load_pte (4'd1, 8'd1, 6'd0, 32'hC000_1234);
        load_pte (4'd1, 8'd1, 6'd1, 32'h4300_0099);
        load_pte (4'd1, 8'd1, 6'd2, 32'hE300_00AB);
        load_pte (4'd1, 8'd1, 6'd3, 32'h8600_BEEF);
        load_pte (4'd1, 8'd1, 6'd4, 32'hA300_0001);
        load_pte (4'd1, 8'd1, 6'd6, 32'hC000_0006);
        load_pte (4'd1, 8'd2, 6'd5, 32'hC300_0042);
        load_pte (4'd2, 8'd3, 6'd0, 32'hD300_7777);

        // R1: context 0 in use after reset
        check_req("R1", 32'h0000_0000, 1'b0, 1'b0, 3'd0, 3'b111, 32'h0005_5000, 3);

        // R11: switch to context 1 for the table
        set_ctx(4'd1);
        for (int i = 0; i < NV; i++) begin
            check_req($sformatf("R%0d", VT[i].rq), VT[i].addr, VT[i].wr, VT[i].usr,
                      VT[i].fault, VT[i].prot, VT[i].pa, int'(VT[i].lat));
        end

        // R11: a context write changes which tables are used
        set_ctx(4'd2);
        check_req("R11", 32'h0000_0000, 1'b0, 1'b0, 3'd0, 3'b111, 32'h0777_7000, 3);

        // R11: context written while busy is not used by that request
        @(negedge clk);
        req_addr = 32'h0000_0000; req_write = 1'b0; req_user = 1'b0; req_valid = 1'b1;
        @(posedge clk);
        @(negedge clk);
        req_valid = 1'b0;
        ctx_wr_en = 1'b1; ctx_wr_val = 4'd1;
        @(negedge clk);
        ctx_wr_en = 1'b0;
        @(negedge clk);
        chk("R11", "done", {31'd0, rsp_done}, 32'd1);
        chk("R11", "paddr", rsp_paddr, 32'h0777_7000);

        // R10: host write collides with write-back on the same entry
        run_req(32'h0000_6000, 1'b0, 1'b0, 1'b1, 32'hC000_0009, f, p, pa, lat, busy);
        chk("R10", "first paddr", pa, 32'h0000_6000);
        chk("R10", "first latency", lat, 4);
        check_req("R10", 32'h0000_6000, 1'b0, 1'b0, 3'd0, 3'b101, 32'h0000_9000, 4);
        check_req("R4", 32'h0000_6000, 1'b0, 1'b0, 3'd0, 3'b101, 32'h0000_9000, 3);

        // R9: done is a single pulse and ready returns
        run_req(32'h0000_0567, 1'b0, 1'b0, 1'b0, 32'd0, f, p, pa, lat, busy);
        @(negedge clk);
        chk("R9", "done dropped", {31'd0, rsp_done}, 32'd0);
        chk("R9", "ready back", {31'd0, req_ready}, 32'd1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule